// File: doc/BRIEF.md
# Self-Timed Page-Buffered Nonvolatile Memory Writer

This block is the memory back end behind a serial programming front end. It takes requests that are already decoded (an opcode, an address and a data byte) and serves them against two arrays that stand in for nonvolatile storage: a word-wide program store and a byte-wide data store. Program words are gathered one byte at a time into a page buffer and then committed as a whole page. Data bytes are written either one at a time or through a small page buffer whose commit changes only the slots that were actually loaded. A chip erase returns both arrays to all ones.

Every commit and erase runs for a fixed, self-timed busy period with its own length for each operation type. The writes into the array take place inside that period. While `busy` is high every request is refused, and the refusal is reported by a one-cycle error pulse. Reads return one byte a cycle after the request. The busy lengths are parameters given in system clocks. The defaults match 4.5 ms, 4.0 ms and 9.0 ms at 8 MHz.

Top module: `nvm_page_writer`

## Requirements
- R1: Opcodes on `reqOp`: 1 load program low byte, 2 load program high byte, 3 commit program page, 4 read program low byte, 5 read program high byte, 6 write single data byte, 7 load data page slot, 8 commit data page, 9 read data byte, 10 chip erase. Codes 0 and 11 to 15 have no effect. After reset, `busy`, `reqError` and `rdValid` are low.
- R2: An accepted opcode 3 raises `busy` on the next cycle and holds it for exactly FLASH_BUSY cycles. Opcodes 6 and 8 hold it for EE_BUSY cycles, and opcode 10 holds it for ERASE_BUSY cycles.
- R3: While `busy` is high, a request with a nonzero opcode is discarded. `reqError` pulses high on the following cycle, and no read data or buffer change results from that request.
- R4: An accepted read sets `rdValid` high on the next cycle, and `rdData` carries the addressed byte: bits 7:0 of the word for opcode 4, bits 15:8 for opcode 5, and the data byte at `reqAddr[5:0]` for opcode 9.
- R5: Program page loads use the 4 low address bits as the slot. A commit uses the address bits above those as the page number and ignores its low 4 bits. Each committed word holds the loaded bytes, and any byte half that was not loaded is stored as 0xFF.
- R6: Data page loads use `reqAddr[1:0]` as the slot. A commit uses `reqAddr[5:2]` as the page number. Only loaded slots change in the array, and every other byte keeps its value.
- R7: A single data byte write leaves the location equal to the new byte, whatever it held before, because the location is erased implicitly before the write.
- R8: Chip erase sets every program word to 0xFFFF and every data byte to 0xFF.
- R9: Both page buffers and their valid bits are cleared by reset and after each commit of that buffer. A commit with no loads writes an all-0xFFFF program page and leaves the data array unchanged.
- R10: A repeated load to the same slot replaces the earlier byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, one cycle per request |
| reqOp | input | 4 | Decoded opcode |
| reqAddr | input | $clog2(FLASH_WORDS) | Word address (program) or byte address in the low bits (data) |
| reqData | input | 8 | Byte to load or write |
| busy | output | 1 | High for the whole self-timed period |
| reqError | output | 1 | One-cycle pulse for a request refused while busy |
| rdData | output | 8 | Byte returned by a read |
| rdValid | output | 1 | High the cycle after an accepted read |

## Verification
The bench builds the block with 64 program words, page sizes at their defaults (16 words and 4 bytes), and busy lengths of 20, 12 and 80 cycles. With these values an erase can still walk every word within its busy window. Each of the four program pages can then be written with its own load pattern, and after every phase both whole arrays are read back and compared with a model. The short busy lengths let the bench count every busy window cycle by cycle and place refused requests inside one.

// File: rtl/nvm_writer_pkg.sv
package nvm_writer_pkg;

  typedef enum logic [3:0] {
    OP_NONE       = 4'd0,
    OP_FL_LOAD_LO = 4'd1,
    OP_FL_LOAD_HI = 4'd2,
    OP_FL_COMMIT  = 4'd3,
    OP_FL_READ_LO = 4'd4,
    OP_FL_READ_HI = 4'd5,
    OP_EE_WRITE   = 4'd6,
    OP_EE_LOAD    = 4'd7,
    OP_EE_COMMIT  = 4'd8,
    OP_EE_READ    = 4'd9,
    OP_ERASE_ALL  = 4'd10
  } nvm_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FL_PAGE,
    ST_EE_PAGE,
    ST_EE_BYTE,
    ST_ERASE
  } nvm_state_e;

  // strobes from control to datapath, each valid for one clock
  typedef struct packed {
    logic latchCmd;
    logic loadFlLo;
    logic loadFlHi;
    logic loadEe;
    logic readFlLo;
    logic readFlHi;
    logic readEe;
    logic flSlotWrite;
    logic eeSlotWrite;
    logic eeByteWrite;
    logic eraseStep;
    logic clearFlBuf;
    logic clearEeBuf;
  } nvm_strobe_t;

endpackage

// File: rtl/nvm_writer_ctrl.sv
module nvm_writer_ctrl
  import nvm_writer_pkg::*;
#(
  parameter int FLASH_WORDS = 512,
  parameter int FLASH_PAGE  = 16,
  parameter int EE_PAGE     = 4,
  parameter int FLASH_BUSY  = 36000,
  parameter int EE_BUSY     = 32000,
  parameter int ERASE_BUSY  = 72000,
  parameter int SW          = 9
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic [3:0]    reqOp,
  output logic          busy,
  output logic          reqError,
  output nvm_strobe_t   stb,
  output logic [SW-1:0] stepIdx
);

  localparam int MAXA = (FLASH_BUSY > EE_BUSY) ? FLASH_BUSY : EE_BUSY;
  localparam int MAXB = (MAXA > ERASE_BUSY) ? MAXA : ERASE_BUSY;
  localparam int MAXC = (MAXB > FLASH_WORDS) ? MAXB : FLASH_WORDS;
  localparam int TW   = $clog2(MAXC + 1);

  localparam logic [TW-1:0] FL_END = TW'(FLASH_BUSY - 1);
  localparam logic [TW-1:0] EE_END = TW'(EE_BUSY - 1);
  localparam logic [TW-1:0] ER_END = TW'(ERASE_BUSY - 1);
  localparam logic [TW-1:0] FL_PG  = TW'(FLASH_PAGE);
  localparam logic [TW-1:0] EE_PG  = TW'(EE_PAGE);
  localparam logic [TW-1:0] FW_N   = TW'(FLASH_WORDS);

  nvm_state_e    state;
  logic [TW-1:0] timer;
  logic [TW-1:0] lastTick;
  logic          accept;

  assign busy    = (state != ST_IDLE);
  assign accept  = reqValid && !busy;
  assign stepIdx = SW'(timer);

  always_comb begin
    case (state)
      ST_FL_PAGE: lastTick = FL_END;
      ST_ERASE:   lastTick = ER_END;
      default:    lastTick = EE_END;
    endcase
  end

  always_comb begin
    stb = '0;
    stb.latchCmd = accept;
    if (accept) begin
      case (reqOp)
        OP_FL_LOAD_LO: stb.loadFlLo = 1'b1;
        OP_FL_LOAD_HI: stb.loadFlHi = 1'b1;
        OP_EE_LOAD:    stb.loadEe   = 1'b1;
        OP_FL_READ_LO: stb.readFlLo = 1'b1;
        OP_FL_READ_HI: stb.readFlHi = 1'b1;
        OP_EE_READ:    stb.readEe   = 1'b1;
        default: ;
      endcase
    end
    case (state)
      ST_FL_PAGE: begin
        stb.flSlotWrite = (timer < FL_PG);
        stb.clearFlBuf  = (timer == lastTick);
      end
      ST_EE_PAGE: begin
        stb.eeSlotWrite = (timer < EE_PG);
        stb.clearEeBuf  = (timer == lastTick);
      end
      ST_EE_BYTE: stb.eeByteWrite = (timer == '0);
      ST_ERASE:   stb.eraseStep   = (timer < FW_N);
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      timer    <= '0;
      reqError <= 1'b0;
    end else begin
      reqError <= reqValid && busy && (reqOp != OP_NONE);
      if (busy) begin
        if (timer == lastTick) begin
          state <= ST_IDLE;
          timer <= '0;
        end else begin
          timer <= timer + 1'b1;
        end
      end else if (accept) begin
        timer <= '0;
        case (reqOp)
          OP_FL_COMMIT: state <= ST_FL_PAGE;
          OP_EE_COMMIT: state <= ST_EE_PAGE;
          OP_EE_WRITE:  state <= ST_EE_BYTE;
          OP_ERASE_ALL: state <= ST_ERASE;
          default:      state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/nvm_writer_dp.sv
module nvm_writer_dp
  import nvm_writer_pkg::*;
#(
  parameter int FLASH_WORDS = 512,
  parameter int FLASH_PAGE  = 16,
  parameter int EE_BYTES    = 64,
  parameter int EE_PAGE     = 4,
  parameter int AW          = 9,
  parameter int SW          = 9
) (
  input  logic          clk,
  input  logic          rstN,
  input  nvm_strobe_t   stb,
  input  logic [SW-1:0] stepIdx,
  input  logic [AW-1:0] reqAddr,
  input  logic [7:0]    reqData,
  output logic [7:0]    rdData,
  output logic          rdValid
);

  localparam int FAW = $clog2(FLASH_WORDS);
  localparam int FPW = $clog2(FLASH_PAGE);
  localparam int EAW = $clog2(EE_BYTES);
  localparam int EPW = $clog2(EE_PAGE);
  localparam logic [SW:0] EE_LIM = (SW + 1)'(EE_BYTES);

  logic [15:0] flashMem [FLASH_WORDS];
  logic [7:0]  eeMem    [EE_BYTES];

  logic [7:0]            flLo [FLASH_PAGE];
  logic [7:0]            flHi [FLASH_PAGE];
  logic [FLASH_PAGE-1:0] flLoV, flHiV;
  logic [7:0]            eeBuf [EE_PAGE];
  logic [EE_PAGE-1:0]    eeV;
  logic [AW-1:0]         cmdAddr;
  logic [7:0]            cmdData;

  logic [FPW-1:0] flSlot;
  logic [FPW-1:0] flLoadSlot;
  logic [FAW-1:0] flWrAddr;
  logic [15:0]    flWrWord;
  logic [EPW-1:0] eeSlot;
  logic [EPW-1:0] eeLoadSlot;
  logic [EAW-1:0] eeWrAddr;
  logic [FAW-1:0] rdFlAddr;

  assign flSlot     = stepIdx[FPW-1:0];
  assign flLoadSlot = reqAddr[FPW-1:0];
  assign flWrAddr   = {cmdAddr[FAW-1:FPW], flSlot};
  assign flWrWord   = {flHiV[flSlot] ? flHi[flSlot] : 8'hFF,
                       flLoV[flSlot] ? flLo[flSlot] : 8'hFF};
  assign eeSlot     = stepIdx[EPW-1:0];
  assign eeLoadSlot = reqAddr[EPW-1:0];
  assign eeWrAddr   = {cmdAddr[EAW-1:EPW], eeSlot};
  assign rdFlAddr   = reqAddr[FAW-1:0];

  // command capture for the self-timed phase
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdAddr <= '0;
      cmdData <= '0;
    end else if (stb.latchCmd) begin
      cmdAddr <= reqAddr;
      cmdData <= reqData;
    end
  end

  // program page buffer
  always_ff @(posedge clk) begin
    if (!rstN || stb.clearFlBuf) begin
      flLoV <= '0;
      flHiV <= '0;
      for (int s = 0; s < FLASH_PAGE; s++) begin
        flLo[s] <= 8'hFF;
        flHi[s] <= 8'hFF;
      end
    end else begin
      if (stb.loadFlLo) begin
        flLo[flLoadSlot]  <= reqData;
        flLoV[flLoadSlot] <= 1'b1;
      end
      if (stb.loadFlHi) begin
        flHi[flLoadSlot]  <= reqData;
        flHiV[flLoadSlot] <= 1'b1;
      end
    end
  end

  // data page buffer
  always_ff @(posedge clk) begin
    if (!rstN || stb.clearEeBuf) begin
      eeV <= '0;
      for (int s = 0; s < EE_PAGE; s++) eeBuf[s] <= 8'hFF;
    end else if (stb.loadEe) begin
      eeBuf[eeLoadSlot] <= reqData;
      eeV[eeLoadSlot]   <= 1'b1;
    end
  end

  // modelled nonvolatile arrays (no reset: contents survive)
  always_ff @(posedge clk) begin
    if (stb.flSlotWrite) flashMem[flWrAddr] <= flWrWord;
    else if (stb.eraseStep) flashMem[stepIdx[FAW-1:0]] <= 16'hFFFF;
  end

  always_ff @(posedge clk) begin
    if (stb.eeSlotWrite) begin
      if (eeV[eeSlot]) eeMem[eeWrAddr] <= eeBuf[eeSlot];
    end else if (stb.eeByteWrite) begin
      eeMem[cmdAddr[EAW-1:0]] <= cmdData;
    end else if (stb.eraseStep && ({1'b0, stepIdx} < EE_LIM)) begin
      eeMem[stepIdx[EAW-1:0]] <= 8'hFF;
    end
  end

  // read port
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= stb.readFlLo || stb.readFlHi || stb.readEe;
      if (stb.readFlLo)      rdData <= flashMem[rdFlAddr][7:0];
      else if (stb.readFlHi) rdData <= flashMem[rdFlAddr][15:8];
      else if (stb.readEe)   rdData <= eeMem[reqAddr[EAW-1:0]];
    end
  end

endmodule

// File: rtl/nvm_page_writer.sv
module nvm_page_writer
  import nvm_writer_pkg::*;
#(
  parameter int FLASH_WORDS = 512,
  parameter int FLASH_PAGE  = 16,
  parameter int EE_BYTES    = 64,
  parameter int EE_PAGE     = 4,
  parameter int FLASH_BUSY  = 36000,
  parameter int EE_BUSY     = 32000,
  parameter int ERASE_BUSY  = 72000,
  localparam int AW         = $clog2(FLASH_WORDS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic [3:0]    reqOp,
  input  logic [AW-1:0] reqAddr,
  input  logic [7:0]    reqData,
  output logic          busy,
  output logic          reqError,
  output logic [7:0]    rdData,
  output logic          rdValid
);

  nvm_strobe_t   stb;
  logic [AW-1:0] stepIdx;

  nvm_writer_ctrl #(
    .FLASH_WORDS(FLASH_WORDS), .FLASH_PAGE(FLASH_PAGE), .EE_PAGE(EE_PAGE),
    .FLASH_BUSY(FLASH_BUSY), .EE_BUSY(EE_BUSY), .ERASE_BUSY(ERASE_BUSY),
    .SW(AW)
  ) ctrlInst (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .busy(busy), .reqError(reqError), .stb(stb), .stepIdx(stepIdx)
  );

  nvm_writer_dp #(
    .FLASH_WORDS(FLASH_WORDS), .FLASH_PAGE(FLASH_PAGE),
    .EE_BYTES(EE_BYTES), .EE_PAGE(EE_PAGE), .AW(AW), .SW(AW)
  ) dpInst (
    .clk(clk), .rstN(rstN), .stb(stb), .stepIdx(stepIdx),
    .reqAddr(reqAddr), .reqData(reqData),
    .rdData(rdData), .rdValid(rdValid)
  );

endmodule

// File: rtl/nvm_page_writer_chk.sv
module nvm_page_writer_chk #(
  parameter int FLASH_BUSY = 36000,
  parameter int EE_BUSY    = 32000,
  parameter int ERASE_BUSY = 72000
) (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic [3:0] reqOp,
  input logic       busy,
  input logic       reqError,
  input logic       rdValid
);

  logic [31:0] runLen;
  logic [31:0] expLen;
  logic        isCommit;
  logic        isRead;

  assign isCommit = (reqOp == 4'd3) || (reqOp == 4'd6) || (reqOp == 4'd8) || (reqOp == 4'd10);
  assign isRead   = (reqOp == 4'd4) || (reqOp == 4'd5) || (reqOp == 4'd9);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runLen <= '0;
      expLen <= '0;
    end else begin
      if (busy) runLen <= runLen + 1;
      else      runLen <= '0;
      if (reqValid && !busy) begin
        case (reqOp)
          4'd3:       expLen <= FLASH_BUSY;
          4'd6, 4'd8: expLen <= EE_BUSY;
          4'd10:      expLen <= ERASE_BUSY;
          default: ;
        endcase
      end
    end
  end

  p_busy_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy && isCommit) |=> busy);

  p_busy_len_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (runLen == expLen));

  p_err_on_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && busy && (reqOp != 4'd0)) |=> reqError);

  p_err_only_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && busy && (reqOp != 4'd0)) |=> !reqError);

  p_no_read_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !rdValid);

  p_read_valid_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy && isRead) |=> rdValid);

  p_read_only_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && !busy && isRead) |=> !rdValid);

endmodule

bind nvm_page_writer nvm_page_writer_chk #(
  .FLASH_BUSY(FLASH_BUSY), .EE_BUSY(EE_BUSY), .ERASE_BUSY(ERASE_BUSY)
) chkInst (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
  .busy(busy), .reqError(reqError), .rdValid(rdValid)
);

// File: tb/nvm_page_writer_test.sv
module nvm_page_writer_test;

  localparam int CLK_PERIOD = 10;
  localparam int FW     = 64;
  localparam int EB     = 64;
  localparam int T_FL   = 20;
  localparam int T_EE   = 12;
  localparam int T_ER   = 80;
  localparam int AW     = $clog2(FW);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [3:0]    reqOp = '0;
  logic [AW-1:0] reqAddr = '0;
  logic [7:0]    reqData = '0;
  logic          busy, reqError, rdValid;
  logic [7:0]    rdData;

  int total = 0;
  int bad = 0;

  logic [15:0] mFl [FW];
  logic [7:0]  mEe [EB];

  always #(CLK_PERIOD / 2) clk = ~clk;

  nvm_page_writer #(
    .FLASH_WORDS(FW), .FLASH_PAGE(16), .EE_BYTES(EB), .EE_PAGE(4),
    .FLASH_BUSY(T_FL), .EE_BUSY(T_EE), .ERASE_BUSY(T_ER)
  ) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqData(reqData), .busy(busy),
    .reqError(reqError), .rdData(rdData), .rdValid(rdValid)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the capture edge
  task automatic issue(input int op, input int addr, input int data);
    reqValid = 1'b1;
    reqOp    = 4'(op);
    reqAddr  = AW'(addr);
    reqData  = 8'(data);
    @(negedge clk);
    reqValid = 1'b0;
    reqOp    = '0;
  endtask

  task automatic waitIdle(output int n);
    n = 0;
    while (busy && n < 100000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic timedCommit(input int op, input int addr, input int expDur, input string req);
    int n;
    issue(op, addr, 0);
    waitIdle(n);
    check(req, n, expDur);
  endtask

  task automatic readByte(input int op, input int addr, input int exp, input string req);
    issue(op, addr, 0);
    check(req, rdValid ? int'(rdData) : 'h1FF, exp);
  endtask

  task automatic verifyAll(input string req);
    for (int w = 0; w < FW; w++) begin
      readByte(4, w, mFl[w][7:0], req);
      readByte(5, w, mFl[w][15:8], req);
    end
    for (int e = 0; e < EB; e++) readByte(9, e, mEe[e], req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 busy at reset", busy, 0);
    check("R1 error at reset", reqError, 0);
    check("R1 rdValid at reset", rdValid, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1: undefined opcodes do nothing
    for (int op = 11; op < 16; op++) begin
      issue(op, 3, 8'h12);
      check("R1 undefined op busy", busy, 0);
      check("R1 undefined op error", reqError, 0);
      check("R1 undefined op rdValid", rdValid, 0);
    end

    // R8: chip erase, R2 erase duration
    timedCommit(10, 0, T_ER, "R2 erase busy length");
    for (int w = 0; w < FW; w++) mFl[w] = 16'hFFFF;
    for (int e = 0; e < EB; e++) mEe[e] = 8'hFF;
    verifyAll("R8 erased");

    // R5 and R10: four program pages with distinct patterns
    for (int p = 0; p < 4; p++) begin
      for (int s = 0; s < 16; s++) begin
        int lo, hi;
        lo = ((p * 16 + s) * 3 + 1) & 'hFF;
        hi = ((p * 37 + s * 5) ^ 'hA5) & 'hFF;
        if (s == 3) issue(1, ((3 - p) << 4) | s, 8'h00); // R10 overwritten below
        issue(1, ((3 - p) << 4) | s, lo);
        if (s % 2 == 0) issue(2, (p << 4) | s, hi);
        mFl[p * 16 + s] = {(s % 2 == 0) ? 8'(hi) : 8'hFF, 8'(lo)};
      end
      timedCommit(3, (p << 4) | ((p * 5 + 7) & 15), T_FL, "R2 program commit busy length");
    end
    verifyAll("R5 R10 program pages");

    // R9: commit with empty buffer gives an erased page
    timedCommit(3, 1 << 4, T_FL, "R2 program commit busy length");
    for (int s = 0; s < 16; s++) mFl[16 + s] = 16'hFFFF;
    verifyAll("R9 empty program commit");

    // R3: requests while busy are refused
    issue(3, 2 << 4, 0);
    check("R3 busy after commit", busy, 1);
    issue(1, 0, 8'h5A);
    check("R3 error pulse on load", reqError, 1);
    issue(4, 0, 0);
    check("R3 error pulse on read", reqError, 1);
    check("R3 no read data", rdValid, 0);
    @(negedge clk);
    check("R3 error is one pulse", reqError, 0);
    waitIdle(n);
    for (int s = 0; s < 16; s++) mFl[32 + s] = 16'hFFFF;
    timedCommit(3, 3 << 4, T_FL, "R2 program commit busy length");
    for (int s = 0; s < 16; s++) mFl[48 + s] = 16'hFFFF;
    check("R3 no error when idle", reqError, 0);
    verifyAll("R3 refused load left no trace");

    // R7: single byte writes
    for (int e = 0; e < EB; e++) begin
      issue(6, e, (e * 7 + 3) & 'hFF);
      waitIdle(n);
      if (e == 0) check("R2 byte write busy length", n, T_EE);
      mEe[e] = 8'((e * 7 + 3) & 'hFF);
    end
    issue(6, 5, 8'h41);
    waitIdle(n);
    mEe[5] = 8'h41;
    verifyAll("R7 byte writes");

    // R6 and R10: partial data page commit
    issue(7, (5 << 2) | 0, 8'hC3);
    issue(7, (1 << 2) | 2, 8'h77);
    issue(7, (7 << 2) | 2, 8'h3C);
    timedCommit(8, (9 << 2) | 1, T_EE, "R2 data page busy length");
    mEe[36] = 8'hC3;
    mEe[38] = 8'h3C;
    verifyAll("R6 R10 partial data page");

    // R9: empty data page commit changes nothing
    timedCommit(8, 9 << 2, T_EE, "R2 data page busy length");
    verifyAll("R9 empty data commit");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule